// File: doc/BRIEF.md
# Multi-Class Linked-List Delay Queue

This block holds packet descriptors for a fixed number of delay classes in a single shared node memory. All class buffers form one ordered list in class order, with class 0 (the most urgent) at the front. A tail pointer and a cumulative occupancy count are kept for every class. Because a class buffer is only a stretch of the list between two tail pointers, admitting a packet, moving a packet to a neighbouring class, and serving one all come down to pointer updates. Stored descriptors never move.

Each class k has a runtime threshold on its cumulative occupancy. The cumulative occupancy of class k is the number of packets held in classes 0 through k. An arrival whose class is full cascades to the next class that has room. When an arrival is admitted into an urgent class, any less urgent class pushed over its threshold hands its last packet to the front of the next class. An external credit generator asks for promotions through a request vector. The port always serves the front of the list.

Top module: `prio_list_q`

## Requirements
- R1: After a synchronous reset the queue is empty: `deq_valid`, `drop`, `viol` and `full` are 0 and `enq_ready` is 1.
- R2: A class-k arrival is stored in class k when the cumulative occupancy of k is below its threshold. No cumulative occupancy ever exceeds its class threshold.
- R3: A class-k arrival that finds class k at its threshold goes to the tail of the first less urgent class with room. One cycle later, `viol` has bit j set (bit j = class j) for every class it skipped.
- R4: After an admission into class c, every class j>c that was exactly at its threshold passes its last packet to the front of class j+1. One cycle later, `viol` bit j is set for each such class.
- R5: An arrival is dropped when no class from its own to the last has room, when the last class is at its threshold, or when no free node is left. One cycle later `drop` pulses with `viol` = 0, and the stored contents are unchanged.
- R6: When `deq_req` is high and the queue is not empty, the next cycle shows `deq_valid`=1, the descriptor at the front of the list, and in `deq_cls` the class that packet holds at that moment. On an empty queue `deq_valid` stays 0.
- R7: In a cycle where a dequeue takes place, `enq_ready` is 0 and the offered arrival is not stored.
- R8: Request bit k of `promo_req` (k from 1 to NCLS-1) moves the first packet of class k to the tail of class k-1. The move is carried out in the first cycle with neither enqueue nor dequeue, and requests seen in busy cycles are held until then. The total count does not change.
- R9: A promotion is carried out even when class k is at its threshold. It is discarded when class k is empty or when class k-1 is at its own threshold.
- R10: `full` is 1 exactly when all NODES nodes hold packets.
- R11: Within a class packets leave in arrival order, and a newly admitted packet is served after every packet already in more urgent or equal classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Arrival offered this cycle |
| enq_cls | input | CW | Requested delay class of the arrival |
| enq_data | input | DW | Descriptor of the arrival |
| enq_ready | output | 1 | Arrival can be taken this cycle (no dequeue) |
| promo_req | input | NCLS-1 | Bit k (index 1..NCLS-1) requests promotion out of class k |
| deq_req | input | 1 | Serve the front of the list |
| deq_valid | output | 1 | Descriptor served by the previous request |
| deq_data | output | DW | Served descriptor |
| deq_cls | output | CW | Class the served packet held when it left |
| lim_flat | input | NCLS*QW | Cumulative thresholds, class k in bits [k*QW +: QW], strictly increasing |
| viol | output | NCLS | One bit per class that suffered an overflow or push-out |
| drop | output | 1 | Arrival was rejected |
| full | output | 1 | Free list exhausted |

## Verification
Two pairs of operations can meet in one cycle. The first pair is a dequeue and an arrival, which are driven in the same cycle. This is judged from `enq_ready` at that edge and from the later drain, which must not contain the offered descriptor. The second pair is an arrival and a promotion request: the request is raised together with an arrival, and the drain order then shows that the promotion took effect in the next idle cycle. Cascaded overflow and multi-level push-out are also checked on a hand-built state. There, `viol` names the exact classes involved, and the drain order and per-packet class confirm that the boundaries moved.

// File: rtl/plq_pkg.sv
package plq_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_DEQ, OP_ENQ} op_e;
endpackage

// File: rtl/plq_admit.sv
// Admission decision: destination class, overflow and push-out sets,
// and the cumulative occupancy after the arrival.
module plq_admit #(
  parameter int NCLS = 8,
  parameter int QW   = 9,
  parameter int CW   = 3
) (
  input  logic [NCLS-1:0][QW-1:0] occ,
  input  logic [NCLS-1:0][QW-1:0] lim,
  input  logic [CW-1:0]           cls,
  input  logic                    room,
  output logic                    ok,
  output logic [CW-1:0]           dst,
  output logic [NCLS-1:0]         ovf,
  output logic [NCLS-1:0]         push,
  output logic [NCLS-1:0][QW-1:0] occ_nx
);
  logic found;

  always_comb begin
    found = 1'b0;
    dst   = '0;
    for (int j = NCLS-1; j >= 0; j--) begin
      if (j >= int'(cls) && occ[j] < lim[j]) begin
        found = 1'b1;
        dst   = j[CW-1:0];
      end
    end
  end

  // total can never grow past the last threshold
  assign ok = found && room && (occ[NCLS-1] < lim[NCLS-1]);

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    assign ovf[g]    = ok && (g >= int'(cls)) && (g < int'(dst));
    assign push[g]   = ok && (g > int'(dst)) && (occ[g] >= lim[g]);
    assign occ_nx[g] = (ok && (g >= int'(dst)) && !push[g]) ? occ[g] + QW'(1) : occ[g];
  end
endmodule

// File: rtl/plq_headcls.sv
// Class of the packet at the front: first class with nonzero cumulative count.
module plq_headcls #(
  parameter int NCLS = 8,
  parameter int QW   = 9,
  parameter int CW   = 3
) (
  input  logic [NCLS-1:0][QW-1:0] occ,
  output logic [CW-1:0]           hcls
);
  always_comb begin
    hcls = '0;
    for (int j = NCLS-1; j >= 0; j--) begin
      if (occ[j] != '0) hcls = j[CW-1:0];
    end
  end
endmodule

// File: rtl/plq_store.sv
// Descriptor memory, one write and one registered read port.
module plq_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/prio_list_q.sv
module prio_list_q #(
  parameter int NCLS  = 8,
  parameter int NODES = 256,
  parameter int DW    = 16,
  localparam int CW   = $clog2(NCLS),
  localparam int QW   = $clog2(NODES+1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enq_valid,
  input  logic [CW-1:0]        enq_cls,
  input  logic [DW-1:0]        enq_data,
  output logic                 enq_ready,
  input  logic [NCLS-1:1]      promo_req,
  input  logic                 deq_req,
  output logic                 deq_valid,
  output logic [DW-1:0]        deq_data,
  output logic [CW-1:0]        deq_cls,
  input  logic [NCLS*QW-1:0]   lim_flat,
  output logic [NCLS-1:0]      viol,
  output logic                 drop,
  output logic                 full
);
  import plq_pkg::*;

  localparam int PW = $clog2(NODES+1);
  localparam int AW = $clog2(NODES);
  localparam logic [PW-1:0] SENT = PW'(NODES);

  // circular doubly linked list through a sentinel; free nodes chained via nxt
  logic [PW-1:0] nxt [NODES+1];
  logic [PW-1:0] prv [NODES+1];
  logic [NCLS-1:0][PW-1:0] tail;
  logic [NCLS-1:0][PW-1:0] tail_enq;
  logic [NCLS-1:0][QW-1:0] occ, lim, occ_nx;
  logic [PW-1:0]   fhead;
  logic [QW-1:0]   nfree;
  logic [NCLS-1:1] pend, prom_eff, pe;

  logic            nonempty, deq_go, enq_go;
  op_e             op;
  logic            ok;
  logic [CW-1:0]   dst, hcls;
  logic [NCLS-1:0] ovf, push;
  logic [PW-1:0]   head, hnext, newn, tins, tnext;

  assign lim       = lim_flat;
  assign nonempty  = occ[NCLS-1] != '0;
  assign deq_go    = deq_req && nonempty;
  assign enq_go    = enq_valid && !deq_go;
  assign enq_ready = !deq_go;
  assign full      = nfree == '0;

  always_comb begin
    if (deq_go)      op = OP_DEQ;
    else if (enq_go) op = OP_ENQ;
    else             op = OP_IDLE;
  end

  plq_admit #(.NCLS(NCLS), .QW(QW), .CW(CW)) u_admit (
    .occ(occ), .lim(lim), .cls(enq_cls), .room(nfree != '0),
    .ok(ok), .dst(dst), .ovf(ovf), .push(push), .occ_nx(occ_nx)
  );

  plq_headcls #(.NCLS(NCLS), .QW(QW), .CW(CW)) u_head (
    .occ(occ), .hcls(hcls)
  );

  plq_store #(.DEPTH(NODES), .DW(DW)) u_store (
    .clk(clk),
    .wr_en(op == OP_ENQ && ok), .wr_addr(newn[AW-1:0]), .wr_data(enq_data),
    .rd_en(op == OP_DEQ), .rd_addr(head[AW-1:0]), .rd_data(deq_data)
  );

  assign head  = nxt[SENT];
  assign hnext = nxt[head];
  assign newn  = fhead;
  assign tins  = tail[dst];
  assign tnext = nxt[tins];

  assign prom_eff = pend | promo_req;
  for (genvar g = 1; g < NCLS; g++) begin : g_pe
    assign pe[g] = prom_eff[g] && (occ[g] != occ[g-1]) && (occ[g-1] < lim[g-1]);
  end

  // new tail of each class after an admission into class dst
  always_comb begin
    for (int j = 0; j < NCLS; j++) begin
      tail_enq[j] = tail[j];
      if (j >= int'(dst)) begin
        if (push[j]) begin
          tail_enq[j] = (occ[j] - QW'(1) == occ[dst]) ? newn : prv[tail[j]];
        end else if (occ[j] == occ[dst]) begin
          tail_enq[j] = newn;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= NODES; k++) begin
        nxt[k] <= (k < NODES-1) ? PW'(k+1) : SENT;
        prv[k] <= SENT;
      end
      for (int j = 0; j < NCLS; j++) begin
        tail[j] <= SENT;
        occ[j]  <= '0;
      end
      fhead     <= '0;
      nfree     <= QW'(NODES);
      pend      <= '0;
      deq_valid <= 1'b0;
      deq_cls   <= '0;
      viol      <= '0;
      drop      <= 1'b0;
    end else begin
      deq_valid <= 1'b0;
      viol      <= '0;
      drop      <= 1'b0;
      case (op)
        OP_DEQ: begin
          pend       <= pend | promo_req;
          nxt[SENT]  <= hnext;
          prv[hnext] <= SENT;
          nxt[head]  <= fhead;
          fhead      <= head;
          nfree      <= nfree + QW'(1);
          deq_valid  <= 1'b1;
          deq_cls    <= hcls;
          for (int j = 0; j < NCLS; j++) begin
            if (occ[j] != '0) occ[j] <= occ[j] - QW'(1);
            if (occ[j] == QW'(1)) tail[j] <= SENT;
          end
        end
        OP_ENQ: begin
          pend <= pend | promo_req;
          if (ok) begin
            nxt[tins]  <= newn;
            nxt[newn]  <= tnext;
            prv[newn]  <= tins;
            prv[tnext] <= newn;
            fhead      <= nxt[fhead];
            nfree      <= nfree - QW'(1);
            occ        <= occ_nx;
            tail       <= tail_enq;
            viol       <= ovf | push;
          end else begin
            drop <= 1'b1;
          end
        end
        default: begin
          pend <= '0;
          for (int g = 1; g < NCLS; g++) begin
            if (pe[g]) begin
              occ[g-1]  <= occ[g-1] + QW'(1);
              tail[g-1] <= nxt[tail[g-1]];
            end
          end
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  for (genvar g = 0; g < NCLS; g++) begin : g_chk
    p_cum_cap_r2: assert property (@(posedge clk) disable iff (rst)
      occ[g] <= lim[g]);
    if (g < NCLS-1) begin : g_ord
      p_cum_order_r11: assert property (@(posedge clk) disable iff (rst)
        occ[g] <= occ[g+1]);
    end
  end

  p_node_cons_r10: assert property (@(posedge clk) disable iff (rst)
    int'(nfree) + int'(occ[NCLS-1]) == NODES);

  p_deq_prec_r7: assert property (@(posedge clk) disable iff (rst)
    (deq_req && nonempty && enq_valid) |=> occ[NCLS-1] == $past(occ[NCLS-1]) - QW'(1));

  p_deq_out_r6: assert property (@(posedge clk) disable iff (rst)
    (deq_req && !nonempty) |=> !deq_valid);

  p_promo_total_r8: assert property (@(posedge clk) disable iff (rst)
    (!enq_valid && !deq_req) |=> $stable(occ[NCLS-1]));

  p_drop_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    drop |-> ($stable(occ) && viol == '0));
endmodule

// File: tb/tb_prio_list_q.sv
module tb_prio_list_q;
  localparam int NCLS = 8, NODES = 256, DW = 16, CW = 3, QW = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, enq_valid, enq_ready, deq_req, deq_valid, drop, full;
  logic [CW-1:0] enq_cls, deq_cls;
  logic [DW-1:0] enq_data, deq_data;
  logic [NCLS-1:1] promo_req;
  logic [NCLS*QW-1:0] lim_flat;
  logic [NCLS-1:0] viol;

  prio_list_q #(.NCLS(NCLS), .NODES(NODES), .DW(DW)) dut (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_cls(enq_cls),
    .enq_data(enq_data), .enq_ready(enq_ready), .promo_req(promo_req),
    .deq_req(deq_req), .deq_valid(deq_valid), .deq_data(deq_data),
    .deq_cls(deq_cls), .lim_flat(lim_flat), .viol(viol), .drop(drop),
    .full(full)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_lim(input int base, input int stp);
    for (int j = 0; j < NCLS; j++) lim_flat[j*QW +: QW] = QW'(base + stp*j);
  endtask

  task automatic do_reset();
    rst = 1'b1; enq_valid = 0; deq_req = 0; promo_req = '0;
    enq_cls = '0; enq_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // op: 0 idle, 1 enqueue, 2 dequeue, 3 both
  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  cls;
    logic [15:0] din;
    logic [7:0]  pro;
    logic        ev;
    logic [15:0] ed;
    logic [2:0]  ec;
    logic [7:0]  eviol;
    logic        edrop;
  } vec_t;

  // thresholds 2,4,6,8,...,16
  localparam vec_t TBL [0:28] = '{
    '{2'd1, 3'd1, 16'h11, 8'h00, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R2
    '{2'd1, 3'd0, 16'h01, 8'h00, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R2
    '{2'd1, 3'd0, 16'h02, 8'h00, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R2
    '{2'd1, 3'd0, 16'h03, 8'h00, 1'b0, 16'h0,  3'd0, 8'h01, 1'b0}, // R3 one step
    '{2'd1, 3'd1, 16'h12, 8'h00, 1'b0, 16'h0,  3'd0, 8'h02, 1'b0}, // R3
    '{2'd1, 3'd2, 16'h21, 8'h00, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R2
    '{2'd1, 3'd1, 16'h13, 8'h00, 1'b0, 16'h0,  3'd0, 8'h06, 1'b0}, // R3 cascade
    '{2'd1, 3'd0, 16'h04, 8'h00, 1'b0, 16'h0,  3'd0, 8'h07, 1'b0}, // R3 cascade x3
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h01, 3'd0, 8'h00, 1'b0}, // R6
    '{2'd1, 3'd1, 16'h14, 8'h00, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R2
    '{2'd1, 3'd0, 16'h05, 8'h00, 1'b0, 16'h0,  3'd0, 8'h0E, 1'b0}, // R4 triple push-out
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h02, 3'd0, 8'h00, 1'b0}, // R6
    '{2'd0, 3'd0, 16'h00, 8'h06, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R8 two at once
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h05, 3'd0, 8'h00, 1'b0}, // R6
    '{2'd1, 3'd1, 16'h15, 8'h00, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R2
    '{2'd0, 3'd0, 16'h00, 8'h02, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R9 at threshold
    '{2'd0, 3'd0, 16'h00, 8'h20, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R9 empty class
    '{2'd1, 3'd3, 16'h31, 8'h08, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R8 held request
    '{2'd0, 3'd0, 16'h00, 8'h00, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}, // R8 applied
    '{2'd3, 3'd0, 16'h77, 8'h00, 1'b1, 16'h11, 3'd0, 8'h00, 1'b0}, // R7
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h03, 3'd0, 8'h00, 1'b0}, // R9 promoted
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h14, 3'd1, 8'h00, 1'b0}, // R4 R8
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h15, 3'd1, 8'h00, 1'b0}, // R11
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h12, 3'd2, 8'h00, 1'b0}, // R3 R4
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h21, 3'd2, 8'h00, 1'b0}, // R8 held
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h13, 3'd3, 8'h00, 1'b0}, // R3
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h31, 3'd3, 8'h00, 1'b0}, // R11
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b1, 16'h04, 3'd4, 8'h00, 1'b0}, // R4
    '{2'd2, 3'd0, 16'h00, 8'h00, 1'b0, 16'h0,  3'd0, 8'h00, 1'b0}  // R6 empty
  };

  task automatic enq1(input logic [2:0] c, input logic [15:0] d);
    enq_valid = 1; enq_cls = c; enq_data = d;
    @(negedge clk);
    enq_valid = 0;
  endtask

  initial begin
    set_lim(2, 2);
    do_reset();
    // R1 reset state
    chk("R1 deq_valid", deq_valid, 0);
    chk("R1 drop", drop, 0);
    chk("R1 viol", viol, 0);
    chk("R1 full", full, 0);
    chk("R1 enq_ready", enq_ready, 1);

    for (int i = 0; i < 29; i++) begin
      enq_valid = TBL[i].op[0];
      deq_req   = TBL[i].op[1];
      enq_cls   = TBL[i].cls;
      enq_data  = TBL[i].din;
      promo_req = TBL[i].pro[7:1];
      #1;
      if (TBL[i].op == 2'd3) chk("R7 enq_ready", enq_ready, 0);
      if (TBL[i].op == 2'd1) chk("R7 enq_ready", enq_ready, 1);
      @(negedge clk);
      chk("R6 deq_valid", deq_valid, TBL[i].ev);
      if (TBL[i].ev) begin
        chk("R6 deq_data", deq_data, TBL[i].ed);
        chk("R6 deq_cls", deq_cls, TBL[i].ec);
      end
      chk("R3 R4 viol", viol, TBL[i].eviol);
      chk("R5 drop", drop, TBL[i].edrop);
      enq_valid = 0; deq_req = 0; promo_req = '0;
    end

    // R5: last class at its threshold blocks every arrival
    do_reset();
    for (int k = 0; k < 16; k++) enq1(3'd7, 16'h700 + 16'(k));
    chk("R5 no drop below limit", drop, 0);
    enq1(3'd7, 16'h7FF);
    chk("R5 drop own class", drop, 1);
    chk("R5 viol on drop", viol, 0);
    enq1(3'd0, 16'h0FF);
    chk("R5 drop urgent class", drop, 1);
    for (int k = 0; k < 16; k++) begin
      deq_req = 1; @(negedge clk); deq_req = 0;
      chk("R11 drain data", deq_data, 16'h700 + 16'(k));
      chk("R6 drain cls", deq_cls, 7);
    end
    deq_req = 1; @(negedge clk); deq_req = 0;
    chk("R5 nothing stored", deq_valid, 0);

    // R10 full flag
    rst = 1'b1; set_lim(300, 20); do_reset();
    for (int k = 0; k < NODES; k++) enq1(3'd7, 16'(k));
    chk("R10 full", full, 1);
    chk("R10 no drop", drop, 0);
    enq1(3'd7, 16'hBEEF);
    chk("R5 drop when full", drop, 1);
    deq_req = 1; @(negedge clk); deq_req = 0;
    chk("R10 deq data", deq_data, 0);
    chk("R10 full clears", full, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule